// File: doc/BRIEF.md
# Edge-detect interrupt controller

This block watches a bank of digital input lines, grouped in ports of eight, for low-to-high and high-to-low transitions. Software picks, for each line, whether a rising edge, a falling edge or both are of interest, using two 8-bit masks per port. Two global enables in the control register can switch all rising or all falling detection on or off.

When a selected edge is detected, a sticky edge flag is set. If another selected edge arrives while that flag is still set, a sticky overflow flag is also set. A single interrupt request combines the two flags. Each flag has its own interrupt enable, and a master enable gates both. Software reads a status register and acknowledges by writing ones to a separate clear register. Reading the status register does not clear it.

The register interface is a byte-wide bus with a write strobe, an address and a combinational read data path. The inputs pass through a synchronizer before edge detection.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the control register (0x03), the status register (0x02) and every mask register read 0x00, and `irq_o` is low.
- R2: A low-to-high change on line i sets status bit 0 when two conditions hold: bit i%8 of the rising mask of port i/8 (address 0x42 + 0x10·port) is set, and control bit 3 is set. The flag becomes visible exactly SYNC_STAGES+1 clock edges after the line changes, which is 3 edges with the default setting.
- R3: A high-to-low change on line i sets status bit 0 when two conditions hold: bit i%8 of the falling mask of port i/8 (address 0x43 + 0x10·port) is set, and control bit 4 is set.
- R4: An edge whose mask bit is clear, or whose global enable in control bit 3 or bit 4 is clear, leaves the status unchanged.
- R5: A selected edge that arrives while status bit 0 is already set sets status bit 1 (overflow). Several lines changing in the same cycle count as one edge.
- R6: Writing to the clear register (0x01) acts on each flag separately. Bit 3 clears the edge flag and bit 2 clears the overflow flag. Address 0x01 reads as 0x00.
- R7: When a clear of the edge flag and a new selected edge fall in the same cycle, the edge flag is left set.
- R8: `irq_o` equals control bit 2 AND ((status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1)).
- R9: Status bit 2 always reads the same value as `irq_o`. Status bits 7..3 read zero.
- R10: The control register reads back its low five bits, with the upper bits as zero. The mask registers read back all eight bits.
- R11: Writing 0x00 to the control register drops `irq_o` at once and leaves status bits 1..0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| lines_i | input | PORTS*8 | Monitored input lines, port p on bits 8p+7..8p |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to bring about is the single cycle in which a software clear and a newly detected edge coincide. The detected edge exists only inside the block, at the end of the synchronizer. To reach it, the bench changes a line on a falling clock edge and counts exactly two rising edges. It then asserts the clear write so that the write is sampled on the same rising edge that latches the detection. The same cycle counting is used to check the latency of the flag. The flag must read clear after two edges and set after the third.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int PORTS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  input  logic [PORTS*8-1:0] lines_i,
  output logic               irq_o
);
  localparam int W = PORTS * 8;
  localparam logic [7:0] A_CLR  = 8'h01;
  localparam logic [7:0] A_STAT = 8'h02;
  localparam logic [7:0] A_CTL  = 8'h03;
  localparam logic [7:0] A_RISE = 8'h42;
  localparam logic [7:0] A_FALL = 8'h43;

  logic [W-1:0] sync_q [SYNC_STAGES];
  logic [W-1:0] prev_q, rise_mask, fall_mask;
  logic [4:0]   ctl_q;
  logic         edge_q, ovf_q;

  wire en_edge_irq = ctl_q[0];
  wire en_ovf_irq  = ctl_q[1];
  wire en_master   = ctl_q[2];
  wire en_rise     = ctl_q[3];
  wire en_fall     = ctl_q[4];

  wire [W-1:0] cur  = sync_q[SYNC_STAGES-1];
  wire [W-1:0] rise = cur & ~prev_q & rise_mask & {W{en_rise}};
  wire [W-1:0] fall = ~cur & prev_q & fall_mask & {W{en_fall}};
  wire         hit  = |(rise | fall);

  wire clr_wr  = bus_wr_i && (bus_addr_i == A_CLR);
  wire clr_edg = clr_wr && bus_wdata_i[3];
  wire clr_ovf = clr_wr && bus_wdata_i[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= lines_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      rise_mask <= '0;
      fall_mask <= '0;
    end else if (bus_wr_i) begin
      if (bus_addr_i == A_CTL) ctl_q <= bus_wdata_i[4:0];
      for (int p = 0; p < PORTS; p++) begin
        if (bus_addr_i == A_RISE + 8'(p << 4)) rise_mask[p*8 +: 8] <= bus_wdata_i;
        if (bus_addr_i == A_FALL + 8'(p << 4)) fall_mask[p*8 +: 8] <= bus_wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (hit)          edge_q <= 1'b1;
      else if (clr_edg) edge_q <= 1'b0;
      if (hit && edge_q) ovf_q <= 1'b1;
      else if (clr_ovf)  ovf_q <= 1'b0;
    end
  end

  assign irq_o = en_master & ((edge_q & en_edge_irq) | (ovf_q & en_ovf_irq));

  always_comb begin
    bus_rdata_o = 8'h00;
    if (bus_addr_i == A_STAT) bus_rdata_o = {5'b0, irq_o, ovf_q, edge_q};
    if (bus_addr_i == A_CTL)  bus_rdata_o = {3'b0, ctl_q};
    for (int p = 0; p < PORTS; p++) begin
      if (bus_addr_i == A_RISE + 8'(p << 4)) bus_rdata_o = rise_mask[p*8 +: 8];
      if (bus_addr_i == A_FALL + 8'(p << 4)) bus_rdata_o = fall_mask[p*8 +: 8];
    end
  end

  // R2 R3
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> edge_q);

  // R4
  no_spurious_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_q) |-> $past(hit));

  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(edge_q) && $past(hit));

  // R6
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edg && !hit) |=> !edge_q);

  // R8
  irq_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_master && (edge_q || ovf_q));
endmodule

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;
  localparam int PORTS = 4;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [PORTS*8-1:0] lines = '0;
  logic irq;
  int checks = 0, errors = 0;

  edge_irq_ctrl #(.PORTS(PORTS), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .lines_i(lines), .irq_o(irq));

  always #10 clk = ~clk;

  // rising mask, falling mask, control, lines before, lines after, expected status
  localparam logic [47:0] VEC [8] = '{
    48'h01_00_0D_00_01_05,
    48'h01_00_0D_01_00_00,
    48'h00_80_15_80_00_05,
    48'h00_80_05_80_00_00,
    48'h02_00_0D_00_01_00,
    48'hFF_00_08_00_F0_01,
    48'h10_10_1C_00_10_01,
    48'h00_0F_11_0F_0E_01
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_now(a, d);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rd_now(8'h03, v); check("R1 control", v, 8'h00);
    rd_now(8'h02, v); check("R1 status", v, 8'h00);
    rd_now(8'h42, v); check("R1 rise mask", v, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    rd_now(8'h73, v); check("R1 fall mask p3", v, 8'h00);

    // R10 readback
    wr_reg(8'h03, 8'hFF); rd_reg(8'h03, v); check("R10 control", v, 8'h1F);
    wr_reg(8'h72, 8'hA5); rd_reg(8'h72, v); check("R10 rise mask p3", v, 8'hA5);
    wr_reg(8'h63, 8'h3C); rd_reg(8'h63, v); check("R10 fall mask p2", v, 8'h3C);
    wr_reg(8'h03, 8'h00); wr_reg(8'h63, 8'h00);

    // table walk: R2 R3 R4 R8 R9
    for (int i = 0; i < 8; i++) begin
      wr_reg(8'h03, VEC[i][31:24]);
      wr_reg(8'h42, VEC[i][47:40]);
      wr_reg(8'h43, VEC[i][39:32]);
      lines[7:0] = VEC[i][23:16];
      settle();
      wr_reg(8'h01, 8'h0C);
      lines[7:0] = VEC[i][15:8];
      settle();
      rd_reg(8'h02, v);
      check($sformatf("R2/R3/R4/R8 vector %0d", i), v, VEC[i][7:0]);
      check($sformatf("R9 vector %0d", i), {5'b0, irq, 2'b0}, {5'b0, v[2], 2'b0});
    end

    // R2 latency: set after exactly 3 edges
    wr_reg(8'h03, 8'h08); wr_reg(8'h42, 8'h01); wr_reg(8'h43, 8'h00);
    lines[7:0] = 8'h00; settle(); wr_reg(8'h01, 8'h0C);
    lines[7:0] = 8'h01;
    @(negedge clk); @(negedge clk); rd_now(8'h02, v); check("R2 not yet after 2 edges", v, 8'h00);
    @(negedge clk); rd_now(8'h02, v); check("R2 set after 3 edges", v, 8'h01);

    // R5 overflow, R8 via overflow enable only
    wr_reg(8'h03, 8'h1E); wr_reg(8'h43, 8'h01);
    lines[7:0] = 8'h00; settle(); wr_reg(8'h01, 8'h0C);
    lines[7:0] = 8'h01; settle();
    rd_reg(8'h02, v); check("R5 first edge no overflow", v, 8'h01);
    check("R8 edge irq disabled", {7'b0, irq}, 8'h00);
    lines[7:0] = 8'h00; settle();
    rd_reg(8'h02, v); check("R5 overflow set", v, 8'h07);
    check("R8 irq via overflow", {7'b0, irq}, 8'h01);

    // R6 independent clears
    wr_reg(8'h01, 8'h08); rd_reg(8'h02, v); check("R6 clear edge only", v, 8'h06);
    wr_reg(8'h01, 8'h04); rd_reg(8'h02, v); check("R6 clear overflow", v, 8'h00);
    rd_reg(8'h01, v); check("R6 clear reg reads zero", v, 8'h00);

    // R2 on port 3 line 31 (rise mask 0x72 bit 7), then R11
    wr_reg(8'h03, 8'h0D);
    lines[31] = 1'b1; settle();
    rd_reg(8'h02, v); check("R2 port3 line31", v, 8'h05);
    wr_reg(8'h03, 8'h00);
    check("R11 irq dropped", {7'b0, irq}, 8'h00);
    rd_reg(8'h02, v); check("R11 status kept", v, 8'h01);
    wr_reg(8'h01, 8'h0C);

    // R7 clear and edge in the same cycle
    wr_reg(8'h03, 8'h08); wr_reg(8'h43, 8'h00);
    lines[7:0] = 8'h00; settle(); wr_reg(8'h01, 8'h0C);
    rd_reg(8'h02, v); check("R7 pre-cleared", v, 8'h00);
    lines[7:0] = 8'h01;
    @(negedge clk); @(negedge clk);
    wr = 1; addr = 8'h01; wdata = 8'h0C;
    @(negedge clk); wr = 0;
    rd_now(8'h02, v); check("R7 edge wins over clear", v, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule